// File: doc/BRIEF.md
# Space Vector PWM Duty Generator

This block turns a voltage command given in the rotating rotor frame (direct and quadrature amplitudes) into three phase duty words for a PWM stage. The caller supplies the sine and cosine of the present electrical angle with the command. A single start strobe begins a computation. The block rotates the command into a stationary two-axis pair, decides which of six sectors the resulting vector falls into, and produces two active phase duties. The third phase is clamped to zero.

All products are formed on one shared multiplier over several cycles. The quotient by the square root of three is replaced by a fixed-point reciprocal constant. Every duty word leaves the block with a fixed marker bit set, so a downstream PWM stage can tell a loaded word from an empty one. Nothing is computed while the enable input is low, and the outputs keep their last values between runs.

Top module: `svpwm_duty_gen`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it is released until the first completed run, `sector` is 0, all three duty words are 0 and `done` is 0.
- R2: With W = DATA_W, the stationary components are alpha = cmdD*angCos + cmdQ*angSin and beta = cmdD*angSin - cmdQ*angCos, computed with signed products and sums that keep only the low W bits (two's-complement wrap).
- R3: The scaled term is term = RECIP * (beta arithmetically shifted right by 16), wrapped to W bits. RECIP defaults to 37837.
- R4: The sector is chosen by signed comparisons. If beta > 0 and alpha > 0, it is 1 when term > alpha, else 0. If beta > 0 and alpha <= 0, it is 2 when term < -alpha, else 1. If beta <= 0 and alpha > 0, it is 5 when term > -alpha, else 4. If beta <= 0 and alpha <= 0, it is 3 when term > alpha, else 4.
- R5: The three phase values are set by sector, using arithmetic right shifts. In sectors 0 and 1: pA = (alpha+term)>>16, pB = term>>15, pC = 0. In sectors 2 and 3: pA = 0, pB = (term-alpha)>>16, pC = (-term-alpha)>>16. In sectors 4 and 5: pA = (alpha-term)>>16, pB = 0, pC = (-term)>>15.
- R6: Each duty word is the low DUTY_W (16) bits of its phase value OR'ed with bit VALID_BIT (14). `duty0` carries pB, `duty1` carries pC and `duty2` carries pA.
- R7: A start sampled high while idle with `enable` high makes `done` high for exactly one cycle. That cycle begins 7 rising edges after the sampling edge. `sector` and the duty words take their new values one cycle before `done`.
- R8: A start sampled while `enable` is low produces no `done` and leaves `sector` and the duties unchanged.
- R9: A start that arrives while a computation is in progress is ignored. The running computation completes with the operands latched at its own start.
- R10: `sector` and the duty words change only on the edge that precedes a `done` pulse. At all other times they hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation (sampled when idle) |
| enable | input | 1 | Gate: a start is accepted only while high |
| cmdD | input | DATA_W | Signed direct-axis amplitude |
| cmdQ | input | DATA_W | Signed quadrature-axis amplitude |
| angSin | input | DATA_W | Signed sine of the electrical angle |
| angCos | input | DATA_W | Signed cosine of the electrical angle |
| sector | output | 3 | Sector number 0..5 of the last result |
| duty0 | output | DUTY_W | Duty word carrying pB |
| duty1 | output | DUTY_W | Duty word carrying pC |
| duty2 | output | DUTY_W | Duty word carrying pA |
| done | output | 1 | One-cycle pulse after the duties update |

## Verification
The bench builds the block with its defaults: DATA_W = 32, DUTY_W = 16, VALID_BIT = 14 and RECIP = 37837. With 32-bit operands, its reference model can use plain signed integer arithmetic, and it can drive one case on purpose where the alpha sum wraps past the sign bit and so changes the sector. The 16-bit duty width puts the marker bit inside the word, next to a payload that may already carry it. The six unit-angle vectors at odd multiples of 30 degrees hit every sector. The zero vector and a vector with beta exactly zero probe the boundaries between sectors.

// File: rtl/svpwm_pkg.sv
package svpwm_pkg;

  // Order of the multiplier passes; the datapath accumulates across them.
  typedef enum logic [2:0] {
    STEP_DCOS = 3'd0,
    STEP_QSIN = 3'd1,
    STEP_DSIN = 3'd2,
    STEP_QCOS = 3'd3,
    STEP_TERM = 3'd4
  } mulStep_e;

  typedef struct packed {
    logic     latchOps;  // capture the command and angle operands
    logic     mulEn;     // perform the multiplier pass given by step
    mulStep_e step;
    logic     writeOut;  // register sector and duty words
  } ctrlStrobe_t;

endpackage

// File: rtl/svpwm_ctrl.sv
module svpwm_ctrl
  import svpwm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        enable,
  output ctrlStrobe_t strb,
  output logic        done
);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_WRITE, S_DONE} state_e;

  state_e   state;
  mulStep_e step;
  logic     accept;

  assign accept = (state == S_IDLE) && start && enable;

  always_comb begin
    strb.latchOps = accept;
    strb.mulEn    = (state == S_MUL);
    strb.step     = step;
    strb.writeOut = (state == S_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      step  <= STEP_DCOS;
      done  <= 1'b0;
    end else begin
      done <= (state == S_DONE);
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            state <= S_MUL;
            step  <= STEP_DCOS;
          end
        end
        S_MUL: begin
          if (step == STEP_TERM) state <= S_WRITE;
          else                   step  <= mulStep_e'(step + 3'd1);
        end
        S_WRITE: state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/svpwm_sector.sv
module svpwm_sector #(
  parameter int DATA_W = 32,
  parameter int SHIFT  = 16
) (
  input  logic signed [DATA_W-1:0] alpha,
  input  logic signed [DATA_W-1:0] beta,
  input  logic signed [DATA_W-1:0] term,
  output logic        [2:0]        sector,
  output logic signed [DATA_W-1:0] phaseA,
  output logic signed [DATA_W-1:0] phaseB,
  output logic signed [DATA_W-1:0] phaseC
);

  localparam logic signed [DATA_W-1:0] ZERO = '0;

  logic signed [DATA_W-1:0] negAlpha, negTerm;
  logic signed [DATA_W-1:0] sumAT, difTA, difAT, negSum;

  always_comb begin
    negAlpha = -alpha;
    negTerm  = -term;
    sumAT    = alpha + term;
    difTA    = term - alpha;
    difAT    = alpha - term;
    negSum   = negTerm - alpha;
  end

  // Quadrant first, then the 60-degree boundary inside it.
  always_comb begin
    if (beta > ZERO) begin
      if (alpha > ZERO) sector = (term > alpha)    ? 3'd1 : 3'd0;
      else              sector = (term < negAlpha) ? 3'd2 : 3'd1;
    end else begin
      if (alpha > ZERO) sector = (term > negAlpha) ? 3'd5 : 3'd4;
      else              sector = (term > alpha)    ? 3'd3 : 3'd4;
    end
  end

  // Bottom-clamped duties: one phase held at zero per sector pair.
  always_comb begin
    if (sector <= 3'd1) begin
      phaseA = sumAT >>> SHIFT;
      phaseB = term >>> (SHIFT - 1);
      phaseC = ZERO;
    end else if (sector <= 3'd3) begin
      phaseA = ZERO;
      phaseB = difTA >>> SHIFT;
      phaseC = negSum >>> SHIFT;
    end else begin
      phaseA = difAT >>> SHIFT;
      phaseB = ZERO;
      phaseC = negTerm >>> (SHIFT - 1);
    end
  end

endmodule

// File: rtl/svpwm_datapath.sv
module svpwm_datapath
  import svpwm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DUTY_W    = 16,
  parameter int VALID_BIT = 14,
  parameter int RECIP     = 37837,
  parameter int SHIFT     = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strb,
  input  logic signed [DATA_W-1:0] cmdD,
  input  logic signed [DATA_W-1:0] cmdQ,
  input  logic signed [DATA_W-1:0] angSin,
  input  logic signed [DATA_W-1:0] angCos,
  output logic        [2:0]        sector,
  output logic        [DUTY_W-1:0] duty0,
  output logic        [DUTY_W-1:0] duty1,
  output logic        [DUTY_W-1:0] duty2
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic signed [DATA_W-1:0] RECIP_W = DATA_W'(RECIP);
  localparam logic [DUTY_W-1:0] VALID_MASK = DUTY_W'(1) << VALID_BIT;

  logic signed [DATA_W-1:0] opD, opQ, opS, opC;
  logic signed [DATA_W-1:0] acc, alpha, beta, term;
  logic signed [DATA_W-1:0] mulA, mulB, prodLo;
  logic signed [PROD_W-1:0] prodFull;

  logic        [2:0]        nxtSector;
  logic signed [DATA_W-1:0] phaseA, phaseB, phaseC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opD <= '0; opQ <= '0; opS <= '0; opC <= '0;
    end else if (strb.latchOps) begin
      opD <= cmdD; opQ <= cmdQ; opS <= angSin; opC <= angCos;
    end
  end

  always_comb begin
    unique case (strb.step)
      STEP_DCOS: begin mulA = opD;     mulB = opC;            end
      STEP_QSIN: begin mulA = opQ;     mulB = opS;            end
      STEP_DSIN: begin mulA = opD;     mulB = opS;            end
      STEP_QCOS: begin mulA = opQ;     mulB = opC;            end
      STEP_TERM: begin mulA = RECIP_W; mulB = beta >>> SHIFT; end
      default:   begin mulA = '0;      mulB = '0;             end
    endcase
  end

  // One shared signed multiplier; only the low word is kept (wraps).
  assign prodFull = $signed({{DATA_W{mulA[DATA_W-1]}}, mulA})
                  * $signed({{DATA_W{mulB[DATA_W-1]}}, mulB});
  assign prodLo   = prodFull[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0; alpha <= '0; beta <= '0; term <= '0;
    end else if (strb.mulEn) begin
      unique case (strb.step)
        STEP_DCOS: acc   <= prodLo;
        STEP_QSIN: alpha <= acc + prodLo;
        STEP_DSIN: acc   <= prodLo;
        STEP_QCOS: beta  <= acc - prodLo;
        STEP_TERM: term  <= prodLo;
        default:   acc   <= acc;
      endcase
    end
  end

  svpwm_sector #(
    .DATA_W (DATA_W),
    .SHIFT  (SHIFT)
  ) u_sector (
    .alpha  (alpha),
    .beta   (beta),
    .term   (term),
    .sector (nxtSector),
    .phaseA (phaseA),
    .phaseB (phaseB),
    .phaseC (phaseC)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sector <= '0;
      duty0  <= '0;
      duty1  <= '0;
      duty2  <= '0;
    end else if (strb.writeOut) begin
      sector <= nxtSector;
      duty0  <= phaseB[DUTY_W-1:0] | VALID_MASK;
      duty1  <= phaseC[DUTY_W-1:0] | VALID_MASK;
      duty2  <= phaseA[DUTY_W-1:0] | VALID_MASK;
    end
  end

endmodule

// File: rtl/svpwm_duty_gen.sv
module svpwm_duty_gen
  import svpwm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DUTY_W    = 16,
  parameter int VALID_BIT = 14,
  parameter int RECIP     = 37837
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              enable,
  input  logic [DATA_W-1:0] cmdD,
  input  logic [DATA_W-1:0] cmdQ,
  input  logic [DATA_W-1:0] angSin,
  input  logic [DATA_W-1:0] angCos,
  output logic [2:0]        sector,
  output logic [DUTY_W-1:0] duty0,
  output logic [DUTY_W-1:0] duty1,
  output logic [DUTY_W-1:0] duty2,
  output logic              done
);

  ctrlStrobe_t strb;

  svpwm_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .enable (enable),
    .strb   (strb),
    .done   (done)
  );

  svpwm_datapath #(
    .DATA_W    (DATA_W),
    .DUTY_W    (DUTY_W),
    .VALID_BIT (VALID_BIT),
    .RECIP     (RECIP),
    .SHIFT     (16)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .cmdD   ($signed(cmdD)),
    .cmdQ   ($signed(cmdQ)),
    .angSin ($signed(angSin)),
    .angCos ($signed(angCos)),
    .sector (sector),
    .duty0  (duty0),
    .duty1  (duty1),
    .duty2  (duty2)
  );

endmodule

// File: rtl/svpwm_checker.sv
module svpwm_checker #(
  parameter int DUTY_W    = 16,
  parameter int VALID_BIT = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        sector,
  input logic [DUTY_W-1:0] duty0,
  input logic [DUTY_W-1:0] duty1,
  input logic [DUTY_W-1:0] duty2,
  input logic              done
);

  localparam logic [DUTY_W-1:0] VALID_ONLY = DUTY_W'(1) << VALID_BIT;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_sector_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    sector <= 3'd5);

  assert_valid_marker_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (duty0[VALID_BIT] && duty1[VALID_BIT] && duty2[VALID_BIT]));

  assert_clamped_phase_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((sector <= 3'd1) ? (duty1 == VALID_ONLY) :
              (sector <= 3'd3) ? (duty2 == VALID_ONLY) :
                                 (duty0 == VALID_ONLY)));

  assert_update_then_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({sector, duty0, duty1, duty2}) |=> done);

endmodule

bind svpwm_duty_gen svpwm_checker #(
  .DUTY_W    (DUTY_W),
  .VALID_BIT (VALID_BIT)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .sector (sector),
  .duty0  (duty0),
  .duty1  (duty1),
  .duty2  (duty2),
  .done   (done)
);

// File: tb/sim_svpwm_duty_gen.sv
`timescale 1ns/1ps
module sim_svpwm_duty_gen;

  logic        clk = 1'b0;
  logic        rstN, start, enable;
  logic [31:0] cmdD, cmdQ, angSin, angCos;
  logic [2:0]  sector;
  logic [15:0] duty0, duty1, duty2;
  logic        done;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  svpwm_duty_gen u0 (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable),
    .cmdD(cmdD), .cmdQ(cmdQ), .angSin(angSin), .angCos(angCos),
    .sector(sector), .duty0(duty0), .duty1(duty1), .duty2(duty2),
    .done(done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference built from the requirement text (R2..R6), 32-bit int arithmetic.
  task automatic model(input int d, q, s, c, output int sec,
                       output logic [15:0] o0, o1, o2);
    int al, be, tm, pa, pb, pc;
    al = d * c + q * s;
    be = d * s - q * c;
    tm = 37837 * (be >>> 16);
    if (be > 0) sec = (al > 0) ? ((tm > al) ? 1 : 0) : ((tm < -al) ? 2 : 1);
    else        sec = (al > 0) ? ((tm > -al) ? 5 : 4) : ((tm > al) ? 3 : 4);
    if (sec <= 1)      begin pa = (al + tm) >>> 16; pb = tm >>> 15; pc = 0; end
    else if (sec <= 3) begin pa = 0; pb = (tm - al) >>> 16; pc = (-tm - al) >>> 16; end
    else               begin pa = (al - tm) >>> 16; pb = 0; pc = (-tm) >>> 15; end
    o0 = pb[15:0] | 16'h4000;
    o1 = pc[15:0] | 16'h4000;
    o2 = pa[15:0] | 16'h4000;
  endtask

  task automatic runVec(input int d, q, s, c, input int expSec, input string name);
    int esec, lat;
    logic [15:0] e0, e1, e2;
    model(d, q, s, c, esec, e0, e1, e2);
    @(negedge clk);
    start = 1'b1; enable = 1'b1;
    cmdD = d; cmdQ = q; angSin = s; angCos = c;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
      if (lat == 6) check(!done && duty0 == e0 && duty2 == e2, "R7 duties before done",
                          {done, duty0, duty2}, {1'b0, e0, e2});
    end
    check(lat == 7, {"R7 latency ", name}, lat, 7);
    check(sector == esec[2:0], {"R4 sector model ", name}, sector, esec);
    if (expSec >= 0) check(sector == expSec[2:0], {"R4 sector expected ", name}, sector, expSec);
    check(duty0 == e0, {"R2 R3 R5 R6 duty0 ", name}, duty0, e0);
    check(duty1 == e1, {"R5 R6 duty1 ", name}, duty1, e1);
    check(duty2 == e2, {"R5 R6 duty2 ", name}, duty2, e2);
    @(negedge clk);
    check(!done, {"R7 single pulse ", name}, done, 0);
  endtask

  task automatic testReset();
    rstN = 1'b0; start = 1'b0; enable = 1'b0;
    cmdD = '0; cmdQ = '0; angSin = '0; angCos = '0;
    repeat (3) @(negedge clk);
    check(sector == 0 && duty0 == 0 && duty1 == 0 && duty2 == 0 && !done,
          "R1 reset state", {sector, duty0, duty1, duty2, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sector == 0 && duty0 == 0 && duty1 == 0 && duty2 == 0 && !done,
          "R1 after release", {sector, duty0, duty1, duty2, done}, 0);
  endtask

  task automatic testSectors();
    runVec(20000, 0,  16384,  28377, 0, "30deg");
    runVec(20000, 0,  32767,      0, 1, "90deg");
    runVec(20000, 0,  16384, -28377, 2, "150deg");
    runVec(20000, 0, -16384, -28377, 3, "210deg");
    runVec(20000, 0, -32767,      0, 4, "270deg");
    runVec(20000, 0, -16384,  28377, 5, "330deg");
    runVec(15000, -9000, -20000, 25000, -1, "mixed dq");
    runVec(-12000, 18000, 23170, -23170, -1, "neg d");
  endtask

  task automatic testBoundaries();
    runVec(0, 0, 0, 0, 4, "zero vector");
    check(duty0 == 16'h4000 && duty1 == 16'h4000 && duty2 == 16'h4000,
          "R6 marker only on zero vector", {duty0, duty1, duty2}, 48'h400040004000);
    runVec(1000, 0, 0, 32767, 5, "beta zero");
    runVec(32'h7fffffff, 0, 0, 2, 3, "R2 alpha wrap");
  endtask

  task automatic testEnableLow();
    logic [15:0] h0, h1, h2;
    logic [2:0]  hs;
    bit sawDone;
    hs = sector; h0 = duty0; h1 = duty1; h2 = duty2;
    @(negedge clk);
    enable = 1'b0; start = 1'b1;
    cmdD = 20000; cmdQ = 0; angSin = 32767; angCos = 0;
    @(negedge clk);
    start = 1'b0;
    sawDone = 0;
    repeat (12) begin @(negedge clk); if (done) sawDone = 1; end
    check(!sawDone, "R8 no done while disabled", sawDone, 0);
    check(sector == hs && duty0 == h0 && duty1 == h1 && duty2 == h2,
          "R8 outputs held while disabled", {sector, duty0, duty1, duty2}, {hs, h0, h1, h2});
    enable = 1'b1;
  endtask

  task automatic testBusyStart();
    int esec, lat, dones;
    logic [15:0] e0, e1, e2;
    model(20000, 0, -16384, -28377, esec, e0, e1, e2);
    @(negedge clk);
    start = 1'b1; enable = 1'b1;
    cmdD = 20000; cmdQ = 0; angSin = -16384; angCos = -28377;
    @(negedge clk);
    start = 1'b0; lat = 0; dones = 0;
    repeat (2) @(negedge clk);
    start = 1'b1; cmdD = 5000; cmdQ = 7000; angSin = 32767; angCos = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (16) begin @(negedge clk); if (done) dones++; end
    check(dones == 1, "R9 one done for overlapping starts", dones, 1);
    check(sector == esec[2:0] && duty0 == e0 && duty1 == e1 && duty2 == e2,
          "R9 result from first operands", {sector, duty0, duty1, duty2}, {esec[2:0], e0, e1, e2});
  endtask

  task automatic testHold();
    logic [15:0] h0, h1, h2;
    logic [2:0]  hs;
    bit moved;
    hs = sector; h0 = duty0; h1 = duty1; h2 = duty2;
    moved = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      cmdD = i * 1234; angSin = -i * 777; angCos = i * 999;
      if (sector != hs || duty0 != h0 || duty1 != h1 || duty2 != h2) moved = 1;
    end
    check(!moved, "R10 outputs hold without start", moved, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testSectors();
    testBoundaries();
    testEnableLow();
    testBusyStart();
    testHold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule